// File: doc/BRIEF.md
# FEC codeword-to-frame mapper

This block lays Reed-Solomon codeword boundaries over a byte stream that is cut into fixed-length data frames, which in turn are grouped into superframes of 68 payload frames (the 69th frame of each superframe carries no payload and shows up only as a gap in the stream). Bytes pass through it unchanged on a valid/ready stream. Each byte that leaves is tagged with strobes that mark the start of a frame, the start of a superframe, the start of a codeword, and whether the byte falls in a check-byte region. A downstream encoder, decoder or interleaver uses these tags to know where each codeword begins and which bytes are parity.

Software supplies a configuration and pulses a load input: frame payload length, codeword length, check-byte count, frames per codeword and path (0 = fast, 1 = interleaved). The block works out the mapping on its own. With one frame per codeword and a codeword as long as the frame, it places one codeword per frame. With one frame per codeword and a shorter codeword that divides the frame, it packs several codewords per frame. With 2 to 20 frames per codeword, on the interleaved path only, it spreads one codeword over several frames. In that mode it places an equal share of the check bytes at the end of every frame. A configuration that fits none of these raises an error flag and blocks the stream.

Back-pressure: a byte moves on a cycle where `in_valid` and `out_ready` are both high while a valid configuration is held. `in_ready` follows `out_ready` and `out_valid` follows `in_valid`, both gated by that condition. Stalls from either side may last any number of cycles, and the byte position does not advance during them.

Top module: `fec_frame_mapper`

## Requirements
- R1: After reset, and before the first configuration load, out_valid and in_ready are 0 and cfg_error is 0.
- R2: With frames-per-codeword 1 and codeword length equal to frame length, cw_start is high on exactly the bytes where frame_start is high, and chk_byte is high on the last check-count bytes of each frame.
- R3: With frames-per-codeword 1 and a codeword length below the frame length that divides it, cw_start is high on every byte whose offset in the frame is a multiple of the codeword length, and chk_byte is high on the last check-count bytes of each codeword.
- R4: With frames-per-codeword F in 2..20, path 1, codeword length F times frame length and a check count divisible by F, cw_start is high on the first byte of every F-th frame, and chk_byte is high on the last check/F bytes of every frame.
- R5: A load with any zero length, a check count not below the codeword length, a codeword that does not divide the frame, a spread codeword on path 0, frames-per-codeword 0 or above 20, a codeword length other than F times the frame length, or a check count not divisible by F sets cfg_error and holds out_valid and in_ready at 0. The next valid load clears cfg_error.
- R6: frame_start is high on the first byte of every frame. sf_start is high on the first byte of every 68th frame, counting from the first frame after a load.
- R7: Codeword position is not reset at a superframe boundary: a codeword in progress continues into the next superframe.
- R8: A byte is taken only when in_valid and out_ready are both high with a valid configuration. in_ready equals out_ready and out_valid equals in_valid under that condition. out_data equals in_data. The strobes do not move during a stall.
- R9: Every configuration load restarts alignment, so the next byte taken is a frame, superframe and codeword start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Pulse: capture and validate the configuration inputs |
| cfg_frame_len | input | LEN_W | Payload bytes per frame |
| cfg_cw_len | input | LEN_W+FPC_W | Bytes per codeword |
| cfg_chk_cnt | input | LEN_W | Check bytes per codeword |
| cfg_frames_per_cw | input | FPC_W | Frames per codeword |
| cfg_path | input | 1 | 0 = fast path, 1 = interleaved path |
| cfg_error | output | 1 | Last loaded configuration was illegal |
| in_valid | input | 1 | Upstream byte valid |
| in_ready | output | 1 | Block accepts a byte |
| in_data | input | 8 | Upstream byte |
| out_valid | output | 1 | Downstream byte valid |
| out_ready | input | 1 | Downstream accepts a byte |
| out_data | output | 8 | Byte passed through |
| frame_start | output | 1 | Byte is the first of a frame |
| sf_start | output | 1 | Byte is the first of a superframe |
| cw_start | output | 1 | Byte is the first of a codeword |
| chk_byte | output | 1 | Byte lies in a check-byte region |

## Verification
The assertions assume that configuration inputs are stable during the cycle `cfg_load` is high. They also assume that no byte is offered on that same cycle, since a load takes priority and realigns the position. The stimulus raises `cfg_load` only while `in_valid` is low, then drops it before offering data. Every stall is a single cycle in which one side is held low, chosen so that the position must hold still across it. Frame and codeword lengths are kept small, so that superframe wrap and codewords running across it are reached within a few hundred bytes.

// File: rtl/fec_map_pkg.sv
package fec_map_pkg;
  typedef enum logic [1:0] {
    MAP_NONE      = 2'd0,
    MAP_ONE       = 2'd1,
    MAP_MULTI_CW  = 2'd2,
    MAP_SPREAD    = 2'd3
  } map_mode_e;
endpackage

// File: rtl/fec_map_cfg_check.sv
module fec_map_cfg_check
  import fec_map_pkg::*;
#(
  parameter int LEN_W   = 8,
  parameter int FPC_W   = 5,
  parameter int MAX_FPC = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_load,
  input  logic [LEN_W-1:0]       frame_len_i,
  input  logic [LEN_W+FPC_W-1:0] cw_len_i,
  input  logic [LEN_W-1:0]       chk_i,
  input  logic [FPC_W-1:0]       fpc_i,
  input  logic                   path_i,
  output map_mode_e              mode_o,
  output logic [LEN_W-1:0]       frame_len_o,
  output logic [LEN_W+FPC_W-1:0] cw_len_o,
  output logic [LEN_W-1:0]       chk_o,
  output logic [LEN_W-1:0]       chk_per_frame_o,
  output logic                   cfg_ok_o,
  output logic                   cfg_error_o
);
  localparam int CW_W = LEN_W + FPC_W;

  logic [CW_W-1:0]  fl_ext, cw_safe, fl_rem, spread_len;
  logic [LEN_W-1:0] fpc_safe, chk_rem, cpf;
  logic             base_ok, legal;
  map_mode_e        mode_n;

  always_comb begin
    fl_ext     = CW_W'(frame_len_i);
    cw_safe    = (cw_len_i == '0) ? CW_W'(1) : cw_len_i;
    fl_rem     = fl_ext % cw_safe;
    fpc_safe   = (fpc_i == '0) ? LEN_W'(1) : LEN_W'(fpc_i);
    chk_rem    = chk_i % fpc_safe;
    cpf        = chk_i / fpc_safe;
    spread_len = CW_W'(fpc_i) * fl_ext;
    base_ok    = (frame_len_i != '0) && (cw_len_i != '0) &&
                 (CW_W'(chk_i) < cw_len_i);
    mode_n     = MAP_NONE;
    if (fpc_i == FPC_W'(1)) begin
      if (fl_rem == '0)
        mode_n = (cw_len_i == fl_ext) ? MAP_ONE : MAP_MULTI_CW;
    end else if (fpc_i >= FPC_W'(2) && int'(fpc_i) <= MAX_FPC) begin
      if (path_i && (cw_len_i == spread_len) && (chk_rem == '0))
        mode_n = MAP_SPREAD;
    end
    legal = base_ok && (mode_n != MAP_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o          <= MAP_NONE;
      frame_len_o     <= '0;
      cw_len_o        <= '0;
      chk_o           <= '0;
      chk_per_frame_o <= '0;
      cfg_ok_o        <= 1'b0;
      cfg_error_o     <= 1'b0;
    end else if (cfg_load) begin
      mode_o          <= legal ? mode_n : MAP_NONE;
      frame_len_o     <= frame_len_i;
      cw_len_o        <= cw_len_i;
      chk_o           <= chk_i;
      chk_per_frame_o <= (mode_n == MAP_SPREAD) ? cpf : chk_i;
      cfg_ok_o        <= legal;
      cfg_error_o     <= !legal;
    end
  end

  // R5: a held configuration is never both usable and flagged
  a_r5_ok_excl_err: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_ok_o && cfg_error_o));
  // R5: a usable configuration always carries a real mapping mode
  a_r5_ok_has_mode: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ok_o |-> (mode_o != MAP_NONE));
endmodule

// File: rtl/fec_map_counters.sv
module fec_map_counters #(
  parameter int LEN_W     = 8,
  parameter int FPC_W     = 5,
  parameter int SF_FRAMES = 68
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   adv,
  input  logic                   cfg_ok,
  input  logic [LEN_W-1:0]       frame_len,
  input  logic [LEN_W+FPC_W-1:0] cw_len,
  output logic [LEN_W-1:0]       byte_in_frame,
  output logic [LEN_W+FPC_W-1:0] byte_in_cw,
  output logic [$clog2(SF_FRAMES)-1:0] frame_in_sf
);
  localparam int CW_W = LEN_W + FPC_W;
  localparam int SF_W = $clog2(SF_FRAMES);

  logic frame_end, cw_end, sf_end;

  assign frame_end = (byte_in_frame == frame_len - LEN_W'(1));
  assign cw_end    = (byte_in_cw == cw_len - CW_W'(1));
  assign sf_end    = (frame_in_sf == SF_W'(SF_FRAMES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_in_frame <= '0;
      byte_in_cw    <= '0;
      frame_in_sf   <= '0;
    end else if (clear) begin
      byte_in_frame <= '0;
      byte_in_cw    <= '0;
      frame_in_sf   <= '0;
    end else if (adv) begin
      byte_in_frame <= frame_end ? '0 : byte_in_frame + LEN_W'(1);
      // codeword position runs independently of the superframe wrap
      byte_in_cw    <= cw_end ? '0 : byte_in_cw + CW_W'(1);
      if (frame_end)
        frame_in_sf <= sf_end ? '0 : frame_in_sf + SF_W'(1);
    end
  end

  // R6: frame position stays inside the configured frame
  a_r6_frame_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ok |-> (byte_in_frame < frame_len));
  // R7: codeword position stays inside the configured codeword
  a_r7_cw_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ok |-> (byte_in_cw < cw_len));
  // R8: no movement without an accepted byte
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clear) |=> ($stable(byte_in_frame) && $stable(byte_in_cw) &&
                          $stable(frame_in_sf)));
endmodule

// File: rtl/fec_frame_mapper.sv
module fec_frame_mapper
  import fec_map_pkg::*;
#(
  parameter int LEN_W     = 8,
  parameter int FPC_W     = 5,
  parameter int MAX_FPC   = 20,
  parameter int SF_FRAMES = 68
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_load,
  input  logic [LEN_W-1:0]       cfg_frame_len,
  input  logic [LEN_W+FPC_W-1:0] cfg_cw_len,
  input  logic [LEN_W-1:0]       cfg_chk_cnt,
  input  logic [FPC_W-1:0]       cfg_frames_per_cw,
  input  logic                   cfg_path,
  output logic                   cfg_error,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [7:0]             in_data,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [7:0]             out_data,
  output logic                   frame_start,
  output logic                   sf_start,
  output logic                   cw_start,
  output logic                   chk_byte
);
  localparam int CW_W = LEN_W + FPC_W;
  localparam int SF_W = $clog2(SF_FRAMES);

  map_mode_e        mode;
  logic [LEN_W-1:0] fl_q, chk_q, cpf_q;
  logic [CW_W-1:0]  cl_q;
  logic             cfg_ok, fire;
  logic [LEN_W-1:0] bif;
  logic [CW_W-1:0]  bic;
  logic [SF_W-1:0]  fis;
  logic             in_chk;

  fec_map_cfg_check #(.LEN_W(LEN_W), .FPC_W(FPC_W), .MAX_FPC(MAX_FPC)) u_cfg (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_load        (cfg_load),
    .frame_len_i     (cfg_frame_len),
    .cw_len_i        (cfg_cw_len),
    .chk_i           (cfg_chk_cnt),
    .fpc_i           (cfg_frames_per_cw),
    .path_i          (cfg_path),
    .mode_o          (mode),
    .frame_len_o     (fl_q),
    .cw_len_o        (cl_q),
    .chk_o           (chk_q),
    .chk_per_frame_o (cpf_q),
    .cfg_ok_o        (cfg_ok),
    .cfg_error_o     (cfg_error)
  );

  assign in_ready  = out_ready && cfg_ok;
  assign out_valid = in_valid && cfg_ok;
  assign out_data  = in_data;
  assign fire      = in_valid && out_ready && cfg_ok && !cfg_load;

  fec_map_counters #(.LEN_W(LEN_W), .FPC_W(FPC_W), .SF_FRAMES(SF_FRAMES)) u_cnt (
    .clk           (clk),
    .rst_n         (rst_n),
    .clear         (cfg_load),
    .adv           (fire),
    .cfg_ok        (cfg_ok),
    .frame_len     (fl_q),
    .cw_len        (cl_q),
    .byte_in_frame (bif),
    .byte_in_cw    (bic),
    .frame_in_sf   (fis)
  );

  always_comb begin
    if (mode == MAP_SPREAD) in_chk = (bif >= fl_q - cpf_q);
    else                    in_chk = (bic >= cl_q - CW_W'(chk_q));
  end

  assign frame_start = out_valid && (bif == '0);
  assign sf_start    = out_valid && (bif == '0) && (fis == '0);
  assign cw_start    = out_valid && (bic == '0);
  assign chk_byte    = out_valid && in_chk;

  // R5: an illegal configuration blocks both sides of the stream
  a_r5_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |-> (!out_valid && !in_ready));
  // R6: a superframe start is always a frame start
  a_r6_sf_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    sf_start |-> frame_start);
  // R2: one codeword per frame keeps both boundaries together
  a_r2_one_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MAP_ONE && out_valid) |-> (cw_start == frame_start));
  // R4: spread codewords begin only on frame boundaries
  a_r4_cw_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MAP_SPREAD && cw_start) |-> frame_start);
  // R9: a load realigns the next byte to all boundaries
  a_r9_realign: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (bif == '0 && bic == '0 && fis == '0));
endmodule

// File: tb/fec_frame_mapper_tb.sv
module fec_frame_mapper_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [7:0]  cfg_frame_len = '0;
  logic [12:0] cfg_cw_len = '0;
  logic [7:0]  cfg_chk_cnt = '0;
  logic [4:0]  cfg_frames_per_cw = '0;
  logic        cfg_path = 1'b0;
  logic        cfg_error;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        frame_start, sf_start, cw_start, chk_byte;

  int n_checks = 0;
  int n_fail   = 0;
  int g_fl, g_cl, g_chk, g_fpc;

  always #(CLK_PERIOD/2) clk = ~clk;

  fec_frame_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
    .cfg_frame_len(cfg_frame_len), .cfg_cw_len(cfg_cw_len),
    .cfg_chk_cnt(cfg_chk_cnt), .cfg_frames_per_cw(cfg_frames_per_cw),
    .cfg_path(cfg_path), .cfg_error(cfg_error),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .frame_start(frame_start), .sf_start(sf_start),
    .cw_start(cw_start), .chk_byte(chk_byte)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // expected strobes for byte number n after the last load
  task automatic model(input int n, output int fs, output int ss,
                       output int cs, output int ch);
    int frame, off, cwoff;
    frame = n / g_fl;
    off   = n % g_fl;
    fs    = (off == 0) ? 1 : 0;
    ss    = (off == 0 && (frame % 68) == 0) ? 1 : 0;
    if (g_fpc > 1) begin
      cs = (off == 0 && (frame % g_fpc) == 0) ? 1 : 0;
      ch = (off >= g_fl - g_chk / g_fpc) ? 1 : 0;
    end else begin
      cwoff = n % g_cl;
      cs = (cwoff == 0) ? 1 : 0;
      ch = (cwoff >= g_cl - g_chk) ? 1 : 0;
    end
  endtask

  task automatic load_cfg(input int fl, input int cl, input int chk,
                          input int fpc, input int path);
    in_valid          = 1'b0;
    cfg_frame_len     = 8'(fl);
    cfg_cw_len        = 13'(cl);
    cfg_chk_cnt       = 8'(chk);
    cfg_frames_per_cw = 5'(fpc);
    cfg_path          = 1'(path);
    cfg_load          = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    g_fl = fl; g_cl = cl; g_chk = chk; g_fpc = fpc;
  endtask

  task automatic check_strobes(input string tag, input int n);
    int fs, ss, cs, ch;
    model(n, fs, ss, cs, ch);
    check({tag, " frame_start"}, int'(frame_start), fs);
    check({tag, " sf_start"},    int'(sf_start), ss);
    check({tag, " cw_start"},    int'(cw_start), cs);
    check({tag, " chk_byte"},    int'(chk_byte), ch);
  endtask

  task automatic stream(input string tag, input int first, input int count,
                        input int stall_every);
    for (int i = first; i < first + count; i++) begin
      if (stall_every > 0 && (i % stall_every) == 1) begin
        in_valid = 1'b0; out_ready = 1'b1;
        #1;
        check("R8 no valid without input", int'(out_valid), 0);
        check("R8 ready follows out_ready", int'(in_ready), 1);
        @(negedge clk);
        in_valid = 1'b1; out_ready = 1'b0; in_data = 8'(i * 7);
        #1;
        check("R8 ready low under backpressure", int'(in_ready), 0);
        check("R8 valid follows in_valid", int'(out_valid), 1);
        check_strobes("R8 held across stall", i);
        @(negedge clk);
      end
      in_valid = 1'b1; out_ready = 1'b1; in_data = 8'(i * 7);
      #1;
      check_strobes(tag, i);
      check("R8 data passthrough", int'(out_data), (i * 7) % 256);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    in_valid = 1'b1; out_ready = 1'b1;
    #1;
    check("R1 out_valid after reset", int'(out_valid), 0);
    check("R1 in_ready after reset", int'(in_ready), 0);
    check("R1 cfg_error after reset", int'(cfg_error), 0);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_one_per_frame();
    load_cfg(5, 5, 2, 1, 0);
    check("R2 legal config", int'(cfg_error), 0);
    stream("R2", 0, 20, 0);
  endtask

  task automatic t_multi_cw();
    load_cfg(12, 4, 2, 1, 1);
    check("R3 legal config", int'(cfg_error), 0);
    stream("R3", 0, 30, 5);
  endtask

  task automatic t_spread();
    load_cfg(4, 12, 3, 3, 1);
    check("R4 legal config", int'(cfg_error), 0);
    stream("R4", 0, 30, 0);
    load_cfg(3, 60, 20, 20, 1);
    check("R4 twenty frames legal", int'(cfg_error), 0);
    stream("R4 f20", 0, 70, 0);
  endtask

  task automatic t_span();
    load_cfg(2, 6, 3, 3, 1);
    stream("R6 R7", 0, 136, 0);
    in_valid = 1'b1; out_ready = 1'b1; in_data = 8'd1;
    #1;
    check("R6 superframe wrap", int'(sf_start), 1);
    check("R7 codeword not restarted at superframe", int'(cw_start), 0);
    @(negedge clk);
    stream("R7 after wrap", 137, 10, 0);
  endtask

  task automatic bad(input string tag, input int fl, input int cl,
                     input int chk, input int fpc, input int path);
    load_cfg(fl, cl, chk, fpc, path);
    in_valid = 1'b1; out_ready = 1'b1;
    #1;
    check({tag, " cfg_error"}, int'(cfg_error), 1);
    check({tag, " out_valid"}, int'(out_valid), 0);
    check({tag, " in_ready"},  int'(in_ready), 0);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_errors();
    bad("R5 non-dividing", 6, 4, 1, 1, 0);
    bad("R5 spread on fast path", 4, 8, 2, 2, 0);
    bad("R5 too many frames", 2, 42, 0, 21, 1);
    bad("R5 check not multiple", 4, 12, 2, 3, 1);
    bad("R5 check too large", 4, 4, 4, 1, 0);
    bad("R5 zero frame", 0, 4, 1, 1, 0);
    bad("R5 zero frames per cw", 4, 4, 1, 0, 0);
    bad("R5 spread length mismatch", 4, 10, 2, 2, 1);
    load_cfg(8, 4, 1, 1, 0);
    check("R5 error cleared", int'(cfg_error), 0);
    stream("R5 recovered", 0, 8, 0);
  endtask

  task automatic t_reload();
    load_cfg(7, 7, 3, 1, 0);
    stream("R9 pre", 0, 10, 0);
    load_cfg(7, 7, 3, 1, 0);
    stream("R9 realigned", 0, 9, 3);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_one_per_frame();
    t_multi_cw();
    t_spread();
    t_span();
    t_errors();
    t_reload();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule